// File: doc/BRIEF.md
# Per-Channel Bank Select and Synchronous Load

This block sits between the calibration datapath and the converter cores of a multi-channel DAC. Each channel has two calibrated codes, one in bank A and one in bank B. A set of grouped select registers, one 8-bit register for every group of eight channels, picks one bank for each channel on its own. A global command can also point every channel at bank A, or every channel at bank B, in one write.

The final DAC registers feed the converters. The host has no direct write path to them. They take new values only through the active-low load strobe `ldac_n`. The strobe is first brought into the clock domain by a one-flop front stage and then by a two-state load controller. The controller's states are LD_IDLE and LD_ACTIVE. It moves from LD_IDLE to LD_ACTIVE when the front stage has captured a low strobe (transition ARM). It moves from LD_ACTIVE back to LD_IDLE when the front stage has captured a high strobe (transition RELEASE). In all other cases it stays in its current state (transitions WAIT and HOLD).

On every clock edge in LD_ACTIVE, all channels reload together from their selected banks.

Top module: `bank_load_top`

## Requirements
- R1: Channel c is controlled by bit (c mod 8) of the select register of group (c div 8). A write with `sel_wr_en`=1 and a group index below 5 replaces that whole 8-bit register with `sel_wr_data` on the next rising edge.
- R2: When a channel is loaded, a select bit of 0 gives that channel's `code_a_i` slice and a select bit of 1 gives its `code_b_i` slice. Channel c occupies bits [16c+15:16c] of each 640-bit bus.
- R3: A group write with an index of 5, 6 or 7 changes no select bit.
- R4: `sel_all_en`=1 sets all 40 select bits to `sel_all_val` on the next edge. If a group write happens in the same cycle, the global command wins.
- R5: After `ldac_n` falls, the outputs keep their old values through the first two rising edges and take the selected codes on the third.
- R6: While the load controller is in LD_ACTIVE, every rising edge reloads all 40 channels. A select write taken at edge e is used by the reload at edge e+1.
- R7: While the load controller is in LD_IDLE, `dac_o` holds its value whatever the codes and select bits do.
- R8: Reset clears all select bits to 0, sets every final DAC code to 0x8000, and puts the controller in LD_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ldac_n | input | 1 | Active-low load strobe, asynchronous to clk |
| sel_wr_en | input | 1 | Group select register write enable |
| sel_wr_grp | input | 3 | Group index of the write |
| sel_wr_data | input | 8 | New select bits for the group |
| sel_all_en | input | 1 | Global select command |
| sel_all_val | input | 1 | Value given to every select bit by the global command |
| code_a_i | input | 640 | Bank A calibrated codes, 16 bits per channel |
| code_b_i | input | 640 | Bank B calibrated codes, 16 bits per channel |
| dac_o | output | 640 | Final DAC codes, 16 bits per channel |

## Verification
The hardest case to reach is a select change landing while the load strobe is already held low. In that case the new selection must appear exactly one edge after the write, with no extra synchronizer delay. The stimulus holds `ldac_n` low through a full sync-and-arm period first. It then writes a group register and samples the outputs after the write edge and again after the following edge. A separate run counts edges after a falling strobe, which pins down the three-edge latency. The bench also changes the codes only once the controller has surely returned to LD_IDLE, so that the hold check is not confused by the trailing reload.

// File: rtl/bank_load_pkg.sv
package bank_load_pkg;
    typedef enum logic [0:0] {
        LD_IDLE   = 1'b0,
        LD_ACTIVE = 1'b1
    } ld_state_e;
endpackage

// File: rtl/bank_sel_regs.sv
module bank_sel_regs #(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_W    = 8,
    parameter int GIDX_W     = 3,
    localparam int CH        = NUM_GROUPS * GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GIDX_W-1:0] wr_grp,
    input  logic [GROUP_W-1:0] wr_data,
    input  logic              all_en,
    input  logic              all_val,
    output logic [CH-1:0]     sel_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (all_en) begin
            sel_q <= {CH{all_val}};
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (wr_grp == GIDX_W'(g)) begin
                    sel_q[g*GROUP_W +: GROUP_W] <= wr_data;
                end
            end
        end
    end

    a_r4_global_set: assert property (@(posedge clk) disable iff (!rst_n)
        all_en |=> (sel_q == {CH{$past(all_val)}}));

    a_r3_bad_group_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !all_en && (int'(wr_grp) >= NUM_GROUPS)) |=> $stable(sel_q));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_wr_chk
        a_r1_group_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !all_en && (wr_grp == GIDX_W'(g)))
                |=> (sel_q[g*GROUP_W +: GROUP_W] == $past(wr_data)));
    end

endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import bank_load_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ldac_n,
    output logic load_en
);

    logic      strobe_s1_q;
    ld_state_e state_q;
    ld_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_s1_q <= 1'b1;
        else        strobe_s1_q <= ldac_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:   if (!strobe_s1_q) state_d = LD_ACTIVE; // ARM, else WAIT
            LD_ACTIVE: if (strobe_s1_q)  state_d = LD_IDLE;   // RELEASE, else HOLD
            default:   state_d = LD_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LD_ACTIVE: load_en = 1'b1;
            default:   load_en = 1'b0;
        endcase
    end

    a_r5_arm_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_s1_q) |=> load_en);

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_s1_q) |=> !load_en);

endmodule

// File: rtl/bank_mux_load.sv
module bank_mux_load #(
    parameter int            CH         = 40,
    parameter int            CODE_W     = 16,
    parameter logic [15:0]   RESET_CODE = 16'h8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [CH-1:0]        sel,
    input  logic [CH*CODE_W-1:0] code_a,
    input  logic [CH*CODE_W-1:0] code_b,
    output logic [CH*CODE_W-1:0] dac_q
);

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [CODE_W-1:0] pick;

        always_comb begin
            pick = sel[c] ? code_b[c*CODE_W +: CODE_W] : code_a[c*CODE_W +: CODE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dac_q[c*CODE_W +: CODE_W] <= CODE_W'(RESET_CODE);
            else if (load_en) dac_q[c*CODE_W +: CODE_W] <= pick;
        end

        a_r2_bank_route: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> (dac_q[c*CODE_W +: CODE_W] ==
                ($past(sel[c]) ? $past(code_b[c*CODE_W +: CODE_W])
                               : $past(code_a[c*CODE_W +: CODE_W]))));
    end

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(dac_q));

endmodule

// File: rtl/bank_load_top.sv
module bank_load_top #(
    parameter int          NUM_GROUPS = 5,
    parameter int          GROUP_W    = 8,
    parameter int          CODE_W     = 16,
    parameter logic [15:0] RESET_CODE = 16'h8000,
    localparam int         CH         = NUM_GROUPS * GROUP_W,
    localparam int         GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ldac_n,
    input  logic                 sel_wr_en,
    input  logic [GIDX_W-1:0]    sel_wr_grp,
    input  logic [GROUP_W-1:0]   sel_wr_data,
    input  logic                 sel_all_en,
    input  logic                 sel_all_val,
    input  logic [CH*CODE_W-1:0] code_a_i,
    input  logic [CH*CODE_W-1:0] code_b_i,
    output logic [CH*CODE_W-1:0] dac_o
);

    logic [CH-1:0] sel;
    logic          load_en;

    bank_sel_regs #(
        .NUM_GROUPS(NUM_GROUPS),
        .GROUP_W   (GROUP_W),
        .GIDX_W    (GIDX_W)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr_en),
        .wr_grp (sel_wr_grp),
        .wr_data(sel_wr_data),
        .all_en (sel_all_en),
        .all_val(sel_all_val),
        .sel_q  (sel)
    );

    load_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ldac_n (ldac_n),
        .load_en(load_en)
    );

    bank_mux_load #(
        .CH        (CH),
        .CODE_W    (CODE_W),
        .RESET_CODE(RESET_CODE)
    ) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(load_en),
        .sel    (sel),
        .code_a (code_a_i),
        .code_b (code_b_i),
        .dac_q  (dac_o)
    );

    a_r8_no_load_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !load_en);

endmodule

// File: tb/bank_load_top_tb.sv
module bank_load_top_tb;
    localparam int NG = 5;
    localparam int CH = 40;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ldac_n = 1'b1;
    logic            sel_wr_en = 1'b0;
    logic [2:0]      sel_wr_grp = '0;
    logic [7:0]      sel_wr_data = '0;
    logic            sel_all_en = 1'b0;
    logic            sel_all_val = 1'b0;
    logic [CH*W-1:0] code_a_i = '0;
    logic [CH*W-1:0] code_b_i = '0;
    logic [CH*W-1:0] dac_o;

    int checks = 0;
    int errors = 0;

    logic [CH-1:0]  m_sel = '0;
    logic [W-1:0]   m_dac [CH];

    localparam logic [10:0] VEC [0:7] = '{
        {3'd0, 8'h01}, {3'd1, 8'h80}, {3'd2, 8'hAA}, {3'd3, 8'h55},
        {3'd4, 8'hF0}, {3'd0, 8'hFF}, {3'd4, 8'h0F}, {3'd2, 8'h00}
    };

    always #5 clk = ~clk;

    bank_load_top u_dut (
        .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n),
        .sel_wr_en(sel_wr_en), .sel_wr_grp(sel_wr_grp), .sel_wr_data(sel_wr_data),
        .sel_all_en(sel_all_en), .sel_all_val(sel_all_val),
        .code_a_i(code_a_i), .code_b_i(code_b_i), .dac_o(dac_o)
    );

    task automatic set_codes(input logic [W-1:0] ba, input logic [W-1:0] bb);
        for (int c = 0; c < CH; c++) begin
            code_a_i[c*W +: W] = ba + W'(c);
            code_b_i[c*W +: W] = bb + W'(c * 3);
        end
    endtask

    task automatic model_load();
        for (int c = 0; c < CH; c++)
            m_dac[c] = m_sel[c] ? code_b_i[c*W +: W] : code_a_i[c*W +: W];
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        int bad = -1;
        checks++;
        for (int c = 0; c < CH; c++)
            if (bad < 0 && dac_o[c*W +: W] !== m_dac[c]) bad = c;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s ch%0d actual %h expected %h", req, bad,
                     dac_o[bad*W +: W], m_dac[bad]);
        end
    endtask

    task automatic grp_write(input logic [2:0] g, input logic [7:0] d);
        sel_wr_en = 1'b1; sel_wr_grp = g; sel_wr_data = d;
        if (int'(g) < NG) m_sel[g*8 +: 8] = d;
        tick(1);
        sel_wr_en = 1'b0;
    endtask

    task automatic pulse_load();
        ldac_n = 1'b0;
        tick(3);
        model_load();
        ldac_n = 1'b1;
        tick(3);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < CH; c++) m_dac[c] = 16'h8000;
        set_codes(16'h1000, 16'hA000);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check_all("R8 reset code");

        // R8: select bits reset to zero -> bank A after a load
        pulse_load();
        check_all("R8 reset select");

        // R1 R2: table walk
        for (int v = 0; v < 8; v++) begin
            set_codes(16'h1000 + W'(v * 64), 16'hA000 + W'(v * 64));
            grp_write(VEC[v][10:8], VEC[v][7:0]);
            pulse_load();
            check_all($sformatf("R1 R2 vector %0d", v));
        end

        // R3: bad group indexes do not touch select bits
        grp_write(3'd5, 8'hFF);
        grp_write(3'd6, 8'hFF);
        grp_write(3'd7, 8'hFF);
        pulse_load();
        check_all("R3 bad group");

        // R4: global set to 1 and to 0
        sel_all_en = 1'b1; sel_all_val = 1'b1; m_sel = '1;
        tick(1); sel_all_en = 1'b0;
        pulse_load();
        check_all("R4 all ones");
        sel_all_en = 1'b1; sel_all_val = 1'b0; m_sel = '0;
        tick(1); sel_all_en = 1'b0;
        pulse_load();
        check_all("R4 all zeros");

        // R4: global wins over same-cycle group write
        sel_all_en = 1'b1; sel_all_val = 1'b1;
        sel_wr_en = 1'b1; sel_wr_grp = 3'd2; sel_wr_data = 8'h00;
        m_sel = '1;
        tick(1);
        sel_all_en = 1'b0; sel_wr_en = 1'b0;
        pulse_load();
        check_all("R4 priority");

        // R7: idle hold under code and select changes
        set_codes(16'h3000, 16'h7000);
        grp_write(3'd1, 8'h3C);
        tick(4);
        check_all("R7 hold");

        // R5: three-edge latency
        ldac_n = 1'b0;
        tick(2);
        check_all("R5 not yet after two edges");
        tick(1);
        model_load();
        check_all("R5 loaded on third edge");

        // R6: continuous load while held low
        set_codes(16'h4400, 16'h5500);
        tick(1);
        model_load();
        check_all("R6 codes follow");
        sel_wr_en = 1'b1; sel_wr_grp = 3'd0; sel_wr_data = 8'hC3;
        @(posedge clk); #1;
        sel_wr_en = 1'b0;
        @(negedge clk);
        check_all("R6 old select at write edge");
        m_sel[7:0] = 8'hC3;
        tick(1);
        model_load();
        check_all("R6 new select next edge");

        ldac_n = 1'b1;
        tick(4);
        set_codes(16'h0100, 16'h0200);
        tick(3);
        check_all("R7 hold after release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule